// File: doc/BRIEF.md
# Word-Packing Flash Program and Erase Controller

This block stands between a byte-wide register bus, driven by a CPU or a DMA engine, and an embedded flash array that can only be programmed one 32-bit word at a time. Software loads a word address through two byte registers and then opens a write session by setting the session bit in the control register. Each byte written to the data register is placed into a 32-bit word, least significant byte first. The fourth byte starts a timed program cycle at the current word address. When the cycle ends, the address moves on to the next word.

The controller raises a DMA request level whenever a session is open and it can take another byte. This lets a DMA channel stream a whole block into the data register. The request is first asserted in the cycle after the session opens. The same timer also runs whole-page erases. The page is chosen by the upper bits of the word address: 64 pages of 512 words, or 2048 bytes each. While either operation runs, the busy flag is high. A read strobe towards the array in that period sets a sticky access-violation flag. Program and erase lengths are clock-cycle parameters.

Top module: `flash_wr_ctrl`

## Requirements
- R1: After reset, busy, session, violation, DMA request, program strobe and erase strobe are all 0.
- R2: A control write (select 0) sets the session to data bit 0. While the session is 1 and busy is 0, dma_req is 1 from the next cycle.
- R3: With the session open and not busy, four data writes (select 3) form one word. The first byte goes in bits 7:0 and the fourth in bits 31:24. From the cycle after the fourth byte, flash_prog and busy are 1, with flash_wdata holding that word and flash_addr the target word address.
- R4: A program operation keeps flash_prog and busy high for exactly PROG_CYC cycles.
- R5: When a program operation ends, flash_addr increases by one. The next word is programmed at that address.
- R6: While busy is 1, dma_req is 0 and data-register writes are dropped.
- R7: Select 1 writes the low byte and select 2 the high byte of the 16-bit word address. Both writes are ignored while busy is 1.
- R8: A control write with bit 1 set while not busy starts an erase. flash_erase and busy stay high for exactly ERASE_CYC cycles, flash_page equals word address bits 14:9, and flash_addr does not change.
- R9: A control write with bit 0 equal to 0 closes the session and discards any partly filled word. A later session starts a new word from its first byte.
- R10: A flash_rd pulse while busy sets viol, and viol stays set. A flash_rd pulse while idle leaves viol at 0. A control write with bit 2 set clears viol.
- R11: Data-register writes while the session is 0 never start a program operation.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_sel | input | 2 | Register select: 0 control, 1 address low, 2 address high, 3 data |
| reg_wdata | input | 8 | Register write data |
| flash_rd | input | 1 | Read access towards the flash array |
| busy | output | 1 | Program or erase in progress |
| session | output | 1 | Write session open |
| dma_req | output | 1 | Data register can take a byte |
| viol | output | 1 | Sticky access-violation flag |
| flash_prog | output | 1 | Word program strobe to the array |
| flash_erase | output | 1 | Page erase strobe to the array |
| flash_addr | output | 16 | Current word address |
| flash_page | output | 6 | Page selected for erase |
| flash_wdata | output | 32 | Word being programmed |

## Verification
The hardest case to reach from the ports is a partly filled word that is thrown away. Catching a fault there needs stray bytes still waiting in the packer when the session closes. To set this up, the stimulus writes two bytes, closes the session, writes four more bytes with the session closed, and then reopens the session and writes a new word. If any stale or ignored byte survives, the scoreboard sees a program operation it did not expect, or a word that does not match. Bytes written while busy are exposed in the same way, because they would shift the lanes of the word that follows.

// File: rtl/flash_ctl_pkg.sv
package flash_ctl_pkg;

  typedef enum logic [1:0] {
    SEL_CTL     = 2'd0,
    SEL_ADDR_LO = 2'd1,
    SEL_ADDR_HI = 2'd2,
    SEL_DATA    = 2'd3
  } reg_sel_e;

  // control register bit positions
  localparam int CTL_SESSION = 0;
  localparam int CTL_ERASE   = 1;
  localparam int CTL_CLRVIOL = 2;

  // place byte b into lane of w, lane 0 = bits 7:0
  function automatic logic [31:0] lane_insert(logic [31:0] w, logic [1:0] lane,
                                              logic [7:0] b);
    logic [31:0] r;
    r = w;
    r[{lane, 3'b000} +: 8] = b;
    return r;
  endfunction

endpackage

// File: rtl/fw_packer.sv
module fw_packer
  import flash_ctl_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        flush,
  input  logic        load,
  input  logic [7:0]  byte_in,
  output logic        word_ready,
  output logic [31:0] word_out,
  output logic [1:0]  fill
);
  logic [31:0] acc;

  assign word_ready = load && (fill == 2'd3);
  assign word_out   = lane_insert(acc, fill, byte_in);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc  <= '0;
      fill <= '0;
    end else if (flush) begin
      acc  <= '0;
      fill <= '0;
    end else if (load) begin
      acc  <= word_ready ? '0 : word_out;
      fill <= fill + 2'd1;
    end
  end

  // R9: a flush leaves the packer empty
  p_flush_empty_r9: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (fill == 2'd0));

  // R3: the fourth byte wraps the fill count back to zero
  p_wrap_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (word_ready && !flush) |=> (fill == 2'd0));

endmodule

// File: rtl/fw_timer.sv
module fw_timer #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [CNT_W-1:0] last,
  output logic             active,
  output logic             done
);
  logic [CNT_W-1:0] cnt;

  assign done = active && (cnt == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active <= 1'b0;
      cnt    <= '0;
    end else if (start) begin
      active <= 1'b1;
      cnt    <= last;
    end else if (done) begin
      active <= 1'b0;
    end else if (active) begin
      cnt <= cnt - 1'b1;
    end
  end

  // R4: no operation is started while another one runs
  p_no_restart_r4: assert property (@(posedge clk) disable iff (!rst_n)
    start |-> !active);

  // R4: the end of an operation drops the active level
  p_done_ends_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !start) |=> !active);

endmodule

// File: rtl/flash_wr_ctrl.sv
module flash_wr_ctrl
  import flash_ctl_pkg::*;
#(
  parameter int ADDR_W     = 16,
  parameter int PAGES      = 64,
  parameter int PAGE_WORDS = 512,
  parameter int PROG_CYC   = 640,
  parameter int ERASE_CYC  = 640000
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     reg_we,
  input  logic [1:0]               reg_sel,
  input  logic [7:0]               reg_wdata,
  input  logic                     flash_rd,
  output logic                     busy,
  output logic                     session,
  output logic                     dma_req,
  output logic                     viol,
  output logic                     flash_prog,
  output logic                     flash_erase,
  output logic [ADDR_W-1:0]        flash_addr,
  output logic [$clog2(PAGES)-1:0] flash_page,
  output logic [31:0]              flash_wdata
);
  localparam int PAGE_W   = $clog2(PAGES);
  localparam int PAGE_LSB = $clog2(PAGE_WORDS);
  localparam int MAX_CYC  = (ERASE_CYC > PROG_CYC) ? ERASE_CYC : PROG_CYC;
  localparam int CNT_W    = $clog2(MAX_CYC + 1);
  localparam logic [CNT_W-1:0] PROG_LAST  = CNT_W'(PROG_CYC - 1);
  localparam logic [CNT_W-1:0] ERASE_LAST = CNT_W'(ERASE_CYC - 1);

  function automatic logic [ADDR_W-1:0] next_word(logic [ADDR_W-1:0] a);
    return a + 1'b1;
  endfunction

  function automatic logic [PAGE_W-1:0] page_of(logic [ADDR_W-1:0] a);
    return a[PAGE_LSB +: PAGE_W];
  endfunction

  logic [ADDR_W-1:0] addr_q;
  logic              erase_op;
  logic              ctl_wr, data_wr, flush;
  logic              prog_go, erase_go, op_done;
  logic [31:0]       packed_word;
  logic [1:0]        fill;

  assign ctl_wr   = reg_we && (reg_sel == SEL_CTL);
  assign data_wr  = reg_we && (reg_sel == SEL_DATA) && session && !busy;
  assign flush    = ctl_wr && !reg_wdata[CTL_SESSION];
  assign erase_go = ctl_wr && reg_wdata[CTL_ERASE] && !busy;

  fw_packer u_pack (
    .clk(clk), .rst_n(rst_n), .flush(flush), .load(data_wr),
    .byte_in(reg_wdata), .word_ready(prog_go), .word_out(packed_word),
    .fill(fill)
  );

  fw_timer #(.CNT_W(CNT_W)) u_tmr (
    .clk(clk), .rst_n(rst_n), .start(prog_go || erase_go),
    .last(erase_go ? ERASE_LAST : PROG_LAST),
    .active(busy), .done(op_done)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      session     <= 1'b0;
      addr_q      <= '0;
      erase_op    <= 1'b0;
      viol        <= 1'b0;
      flash_wdata <= '0;
    end else begin
      if (ctl_wr) session <= reg_wdata[CTL_SESSION];
      if (!busy && reg_we && reg_sel == SEL_ADDR_LO) addr_q[7:0] <= reg_wdata;
      if (!busy && reg_we && reg_sel == SEL_ADDR_HI) addr_q[ADDR_W-1:8] <= reg_wdata[ADDR_W-9:0];
      if (op_done && !erase_op) addr_q <= next_word(addr_q);
      if (prog_go) begin
        erase_op    <= 1'b0;
        flash_wdata <= packed_word;
      end else if (erase_go) begin
        erase_op <= 1'b1;
      end
      if (ctl_wr && reg_wdata[CTL_CLRVIOL]) viol <= 1'b0;
      if (flash_rd && busy) viol <= 1'b1;
    end
  end

  assign dma_req     = session && !busy;
  assign flash_prog  = busy && !erase_op;
  assign flash_erase = busy && erase_op;
  assign flash_addr  = addr_q;
  assign flash_page  = page_of(addr_q);

  // R3: the fourth byte starts a program cycle
  p_start_prog_r3: assert property (@(posedge clk) disable iff (!rst_n)
    prog_go |=> flash_prog);

  // R5: the word address steps by one after each program
  p_addr_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (op_done && !erase_op) |=> (flash_addr == $past(flash_addr) + 1'b1));

  // R6: no DMA request while busy
  p_dma_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !dma_req);

  // R8: erase leaves the address unchanged
  p_erase_addr_r8: assert property (@(posedge clk) disable iff (!rst_n)
    flash_erase |=> $stable(flash_addr));

  // R10: a read during an operation is caught
  p_viol_catch_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (flash_rd && busy) |=> viol);

  // R11: no program starts without a session
  p_no_sess_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (!session && !busy) |=> !flash_prog);

endmodule

// File: tb/flash_wr_ctrl_test.sv
module flash_wr_ctrl_test;
  localparam int CLK_NS = 10;
  localparam int PROG   = 8;
  localparam int ERASE  = 40;

  logic clk = 0, rst_n = 0;
  logic reg_we = 0, flash_rd = 0;
  logic [1:0] reg_sel = 0;
  logic [7:0] reg_wdata = 0;
  logic busy, session, dma_req, viol, flash_prog, flash_erase;
  logic [15:0] flash_addr;
  logic [5:0]  flash_page;
  logic [31:0] flash_wdata;

  int errors = 0, checks = 0;
  bit finished = 0;
  logic [47:0] expq[$];

  always #(CLK_NS/2) clk = ~clk;

  flash_wr_ctrl #(.PROG_CYC(PROG), .ERASE_CYC(ERASE)) uut (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_sel(reg_sel),
    .reg_wdata(reg_wdata), .flash_rd(flash_rd), .busy(busy),
    .session(session), .dma_req(dma_req), .viol(viol),
    .flash_prog(flash_prog), .flash_erase(flash_erase),
    .flash_addr(flash_addr), .flash_page(flash_page),
    .flash_wdata(flash_wdata)
  );

  task automatic check(input bit ok, input string req, input longint act,
                       input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] sel, input logic [7:0] d);
    @(negedge clk);
    reg_we = 1; reg_sel = sel; reg_wdata = d;
    @(negedge clk);
    reg_we = 0;
  endtask

  // driver: queue the expected word, then feed its bytes lowest first
  task automatic send_word(input logic [15:0] a, input logic [31:0] w);
    expq.push_back({a, w});
    for (int i = 0; i < 4; i++) wr(2'd3, w[i*8 +: 8]);
  endtask

  task automatic rd_pulse();
    @(negedge clk); flash_rd = 1;
    @(negedge clk); flash_rd = 0;
  endtask

  task automatic wait_idle();
    while (busy) @(negedge clk);
  endtask

  // monitor: scoreboard for programs, length checks for both operations
  logic prev_prog = 0, prev_erase = 0;
  int plen = 0, elen = 0;
  always @(negedge clk) begin
    if (rst_n) begin
      if (flash_prog && !prev_prog) begin
        if (expq.size() == 0) check(0, "R3/R11 unexpected program", flash_wdata, 0);
        else begin
          logic [47:0] e;
          e = expq.pop_front();
          check(flash_addr == e[47:32], "R5 program address", flash_addr, e[47:32]);
          check(flash_wdata == e[31:0], "R3 program word", flash_wdata, e[31:0]);
        end
      end
      if (flash_prog) plen++;
      else if (prev_prog) begin
        check(plen == PROG, "R4 program length", plen, PROG);
        plen = 0;
      end
      if (flash_erase) elen++;
      else if (prev_erase) begin
        check(elen == ERASE, "R8 erase length", elen, ERASE);
        elen = 0;
      end
      prev_prog = flash_prog;
      prev_erase = flash_erase;
    end
  end

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=done");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    check({busy, session, viol, dma_req, flash_prog, flash_erase} == 6'b0,
          "R1 reset outputs", {busy, session, viol, dma_req, flash_prog, flash_erase}, 0);

    // R7 address bytes
    wr(2'd1, 8'h10); wr(2'd2, 8'h00);
    check(flash_addr == 16'h0010, "R7 address load", flash_addr, 16'h0010);

    // R2 session opens, DMA request follows
    wr(2'd0, 8'h01);
    check(session == 1, "R2 session", session, 1);
    check(dma_req == 1, "R2 dma_req", dma_req, 1);

    // R3 first word; R6 during busy
    send_word(16'h0010, 32'h44332211);
    check(busy == 1 && flash_prog == 1, "R3 program started", {busy, flash_prog}, 2'b11);
    check(dma_req == 0, "R6 dma_req low while busy", dma_req, 0);
    wr(2'd3, 8'hAA);            // R6: must be dropped
    wr(2'd1, 8'h55);            // R7: must be ignored while busy
    check(flash_addr == 16'h0010, "R7 address held while busy", flash_addr, 16'h0010);
    wait_idle();
    check(flash_addr == 16'h0011, "R5 address increment", flash_addr, 16'h0011);
    check(dma_req == 1, "R2 dma_req after program", dma_req, 1);

    // R5/R6 second word proves the dropped byte is gone
    send_word(16'h0011, 32'h0D0C0B0A);
    wait_idle();

    // R9 partial word discarded
    wr(2'd3, 8'h77); wr(2'd3, 8'h88);
    wr(2'd0, 8'h00);
    check(session == 0 && dma_req == 0, "R9 session closed", {session, dma_req}, 0);
    // R11 bytes without a session
    for (int i = 0; i < 4; i++) wr(2'd3, 8'h99);
    repeat (2) @(negedge clk);
    check(flash_prog == 0 && busy == 0, "R11 no program without session", {flash_prog, busy}, 0);
    wr(2'd0, 8'h01);
    send_word(16'h0012, 32'h04030201);
    wait_idle();
    check(flash_addr == 16'h0013, "R9 fresh word programmed", flash_addr, 16'h0013);

    // R10 idle read is harmless
    rd_pulse();
    check(viol == 0, "R10 idle read", viol, 0);

    // R8 erase of page 5 (word address 0x0A00)
    wr(2'd0, 8'h00);
    wr(2'd1, 8'h00); wr(2'd2, 8'h0A);
    wr(2'd0, 8'h02);
    check(flash_erase == 1 && busy == 1 && flash_prog == 0, "R8 erase started",
          {flash_erase, busy, flash_prog}, 3'b110);
    check(flash_page == 6'd5, "R8 erase page", flash_page, 5);
    rd_pulse();
    check(viol == 1, "R10 violation set", viol, 1);
    wait_idle();
    check(flash_addr == 16'h0A00, "R8 address kept after erase", flash_addr, 16'h0A00);
    check(viol == 1, "R10 violation sticky", viol, 1);
    wr(2'd0, 8'h04);
    check(viol == 0, "R10 violation cleared", viol, 0);
    check(expq.size() == 0, "R3 all words programmed", expq.size(), 0);

    repeat (2) @(negedge clk);
    finish_run();
  end
endmodule